// File: doc/BRIEF.md
# Scan Vector Sequencer

This block decides which stored scan vector runs next and how many times it runs. A small internal list holds up to sixteen entries. Each entry has a 3-bit vector code and an 8-bit repeat count. On a start pulse with the sequencer enabled, the block loads an outer pass count. It then walks the list from entry 0. For every iteration of every entry it raises a one-cycle execute request to a downstream macro engine and waits for that engine to report completion.

Three conditions end the current pass: a terminator code, an unused code, or running past the last entry. Each one decrements the pass count and restarts the walk at entry 0. An entry whose repeat count is zero is passed over without a request. The run stops early if the selected vector's pre-load flag is clear. When the sequencer is disabled, a start pulse with a non-zero legal vector select runs that one vector once. Status outputs report sequencer activity, which single vector is active, and a sticky compare-failure flag.

Top module: `vecseq_top`

## Requirements
- R1: After reset the block is idle: `exec_req_o`, `seq_busy_o`, `vec_busy_o` and `cmp_result_o` are all 0.
- R2: A start pulse with `seq_en_i`=1 while idle clears `cmp_result_o` and sets `seq_busy_o` on the next cycle.
- R3: When the pass count reaches or starts at zero, `seq_busy_o` drops to 0 and no further request is issued. A count of 0 therefore issues no request at all.
- R4: A list entry with a legal code (1 to 4) and repeat count N issues N requests, each carrying that code on `exec_vec_o`. Entries are served in ascending address order.
- R5: Code 0 ends the current pass. The whole list, restarted at entry 0, runs once per unit of the pass count.
- R6: Codes 5, 6 and 7 are unused and end the pass exactly as code 0 does.
- R7: An entry with a legal code and a repeat count of 0 issues no request, and the walk moves to the next entry.
- R8: After entry 15 has been served, the pass ends even though no terminator code was found.
- R9: When an entry with a non-zero count selects a code whose bit in `preload_i` is clear, the run stops. `seq_busy_o` falls and no request is issued for that code. Bit k of `preload_i` belongs to code k+1.
- R10: With `seq_en_i`=0, a start pulse with a legal `vec_sel_i` issues exactly one request for that code. It sets bit (code-1) of `vec_busy_o` from the next cycle until completion.
- R11: With `seq_en_i`=0 and `vec_sel_i` equal to 0 or an unused code (5 to 7), a start pulse is ignored and the block stays idle.
- R12: `cmp_result_o` is set when a completion arrives with `exec_mismatch_i`=1. It stays set until the next sequencer start.
- R13: A request lasts one cycle, and the next request comes only after a completion. A completion pulse while no request is outstanding has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, honoured while idle |
| seq_en_i | input | 1 | Select list-driven run |
| vec_sel_i | input | 3 | Vector code for a single run |
| seq_rpt_i | input | 8 | Pass count, sampled on a sequencer start |
| preload_i | input | 4 | Pre-load flag per legal code |
| ent_we_i | input | 1 | List write enable |
| ent_addr_i | input | 4 | List write address |
| ent_vnum_i | input | 3 | Vector code to write |
| ent_rpt_i | input | 8 | Repeat count to write |
| exec_req_o | output | 1 | One-cycle execute request |
| exec_vec_o | output | 3 | Code of the requested vector |
| exec_done_i | input | 1 | Completion pulse from the macro engine |
| exec_mismatch_i | input | 1 | Compare failure, qualified by completion |
| seq_busy_o | output | 1 | Sequencer run in progress |
| vec_busy_o | output | 4 | One-hot active single vector |
| cmp_result_o | output | 1 | Sticky compare-failure flag |

## Verification
The bound checker checks these properties on every cycle:
- a request lasts one cycle and always carries a legal code;
- a request is only issued while a run is active;
- sequencer and single-vector status never overlap, and `vec_busy_o` is at most one-hot;
- a sequencer start clears the compare flag, and the flag is otherwise sticky;
- the block falls idle after an abort or after the last pass;
- an ignored start leaves the block idle.

The order and number of requests can only be shown by the bench's scenarios. These include passes cut short by terminator or unused codes, skipped zero-count entries, a full list with no terminator, and a run stopped part-way by a missing pre-load flag. The bench compares every request against a list walk it computes for itself.

// File: rtl/vecseq_pkg.sv
package vecseq_pkg;

  typedef enum logic [2:0] {
    S_IDLE   = 3'd0,
    S_SEQCHK = 3'd1,
    S_ENTRY  = 3'd2,
    S_RPTCHK = 3'd3,
    S_FETCH  = 3'd4,
    S_ISSUE  = 3'd5,
    S_WAIT   = 3'd6
  } vs_state_e;

  // A code is legal when it names one of the stored vectors 1..nvec.
  function automatic logic code_legal(input int unsigned code, input int unsigned nvec);
    return (code != 0) && (code <= nvec);
  endfunction

endpackage

// File: rtl/vecseq_dec.sv
module vecseq_dec #(
  parameter int VNUM_W = 3,
  parameter int NVEC   = 4
) (
  input  logic [VNUM_W-1:0] code_i,
  output logic              legal_o,
  output logic [NVEC-1:0]   onehot_o
);
  import vecseq_pkg::*;

  assign legal_o = code_legal(int'(code_i), NVEC);

  for (genvar k = 0; k < NVEC; k++) begin : g_bit
    assign onehot_o[k] = (code_i == VNUM_W'(k + 1));
  end

endmodule

// File: rtl/vecseq_dncnt.sv
module vecseq_dncnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         dec_i,
  output logic [W-1:0] cnt_o,
  output logic         zero_o
);

  function automatic logic [W-1:0] dec_sat(input logic [W-1:0] v);
    return (v == '0) ? v : v - W'(1);
  endfunction

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (load_i) cnt_q <= load_val_i;
    else if (dec_i)  cnt_q <= dec_sat(cnt_q);
  end

  assign cnt_o  = cnt_q;
  assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/vecseq_entry_mem.sv
module vecseq_entry_mem #(
  parameter int ENTRIES = 16,
  parameter int VNUM_W  = 3,
  parameter int RPT_W   = 8,
  localparam int PTR_W  = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_i,
  input  logic [PTR_W-1:0]  waddr_i,
  input  logic [VNUM_W-1:0] wvnum_i,
  input  logic [RPT_W-1:0]  wrpt_i,
  input  logic [PTR_W-1:0]  raddr_i,
  output logic [VNUM_W-1:0] rvnum_o,
  output logic [RPT_W-1:0]  rrpt_o
);

  logic [VNUM_W-1:0] vnum_q [ENTRIES];
  logic [RPT_W-1:0]  rpt_q  [ENTRIES];

  for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vnum_q[e] <= '0;
        rpt_q[e]  <= '0;
      end else if (we_i && (waddr_i == PTR_W'(e))) begin
        vnum_q[e] <= wvnum_i;
        rpt_q[e]  <= wrpt_i;
      end
    end
  end

  assign rvnum_o = vnum_q[raddr_i];
  assign rrpt_o  = rpt_q[raddr_i];

endmodule

// File: rtl/vecseq_top.sv
module vecseq_top #(
  parameter int ENTRIES = 16,
  parameter int VNUM_W  = 3,
  parameter int RPT_W   = 8,
  parameter int SEQ_W   = 8,
  parameter int NVEC    = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start_i,
  input  logic                       seq_en_i,
  input  logic [VNUM_W-1:0]          vec_sel_i,
  input  logic [SEQ_W-1:0]           seq_rpt_i,
  input  logic [NVEC-1:0]            preload_i,
  input  logic                       ent_we_i,
  input  logic [$clog2(ENTRIES)-1:0] ent_addr_i,
  input  logic [VNUM_W-1:0]          ent_vnum_i,
  input  logic [RPT_W-1:0]           ent_rpt_i,
  output logic                       exec_req_o,
  output logic [VNUM_W-1:0]          exec_vec_o,
  input  logic                       exec_done_i,
  input  logic                       exec_mismatch_i,
  output logic                       seq_busy_o,
  output logic [NVEC-1:0]            vec_busy_o,
  output logic                       cmp_result_o
);
  import vecseq_pkg::*;

  localparam int PTR_W = $clog2(ENTRIES);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(ENTRIES - 1);
  localparam int NDEC = 3;  // list read port, single-run select, current vector

  vs_state_e         state_q, state_d;
  logic [PTR_W-1:0]  ptr_q;
  logic [VNUM_W-1:0] cur_vec_q;
  logic              seq_mode_q;
  logic              seq_busy_q;
  logic [NVEC-1:0]   vec_busy_q;
  logic              cmp_q;

  logic [VNUM_W-1:0] rd_vnum;
  logic [RPT_W-1:0]  rd_rpt;

  // Code decoders, one per code source.
  logic [VNUM_W-1:0] dec_code  [NDEC];
  logic              dec_legal [NDEC];
  logic [NVEC-1:0]   dec_oh    [NDEC];

  assign dec_code[0] = rd_vnum;
  assign dec_code[1] = vec_sel_i;
  assign dec_code[2] = cur_vec_q;

  for (genvar d = 0; d < NDEC; d++) begin : g_dec
    vecseq_dec #(.VNUM_W(VNUM_W), .NVEC(NVEC)) u_dec (
      .code_i  (dec_code[d]),
      .legal_o (dec_legal[d]),
      .onehot_o(dec_oh[d])
    );
  end

  // Named internal events.
  logic in_idle, in_wait;
  logic ev_seq_go, ev_vec_go;
  logic ev_pass_end, ev_seq_finish, ev_abort;
  logic ev_rpt_load, ev_done, ev_rpt_dec;
  logic seq_zero, rpt_zero, pre_ok;
  logic [SEQ_W-1:0] seq_cnt;
  logic [RPT_W-1:0] rpt_cnt;

  assign in_idle = (state_q == S_IDLE);
  assign in_wait = (state_q == S_WAIT);
  assign ev_seq_go = in_idle && start_i && seq_en_i;
  assign ev_vec_go = in_idle && start_i && !seq_en_i && dec_legal[1];
  assign pre_ok    = |(preload_i & dec_oh[2]);

  assign ev_pass_end = ((state_q == S_ENTRY) && !dec_legal[0]) ||
                       ((state_q == S_RPTCHK) && rpt_zero && (ptr_q == LAST));
  assign ev_seq_finish = (state_q == S_SEQCHK) && seq_zero;
  assign ev_abort      = (state_q == S_FETCH) && !pre_ok;
  assign ev_rpt_load   = (state_q == S_ENTRY) && dec_legal[0];
  assign ev_done       = in_wait && exec_done_i;
  assign ev_rpt_dec    = ev_done && seq_mode_q;

  vecseq_entry_mem #(.ENTRIES(ENTRIES), .VNUM_W(VNUM_W), .RPT_W(RPT_W)) u_mem (
    .clk    (clk),
    .rst_n  (rst_n),
    .we_i   (ent_we_i),
    .waddr_i(ent_addr_i),
    .wvnum_i(ent_vnum_i),
    .wrpt_i (ent_rpt_i),
    .raddr_i(ptr_q),
    .rvnum_o(rd_vnum),
    .rrpt_o (rd_rpt)
  );

  vecseq_dncnt #(.W(SEQ_W)) u_seq_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_i    (ev_seq_go),
    .load_val_i(seq_rpt_i),
    .dec_i     (ev_pass_end),
    .cnt_o     (seq_cnt),
    .zero_o    (seq_zero)
  );

  vecseq_dncnt #(.W(RPT_W)) u_rpt_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_i    (ev_rpt_load),
    .load_val_i(rd_rpt),
    .dec_i     (ev_rpt_dec),
    .cnt_o     (rpt_cnt),
    .zero_o    (rpt_zero)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE: begin
        if (ev_seq_go)      state_d = S_SEQCHK;
        else if (ev_vec_go) state_d = S_ISSUE;
      end
      S_SEQCHK: state_d = seq_zero ? S_IDLE : S_ENTRY;
      S_ENTRY:  state_d = dec_legal[0] ? S_RPTCHK : S_SEQCHK;
      S_RPTCHK: begin
        if (!rpt_zero)          state_d = S_FETCH;
        else if (ptr_q == LAST) state_d = S_SEQCHK;
        else                    state_d = S_ENTRY;
      end
      S_FETCH: state_d = pre_ok ? S_ISSUE : S_IDLE;
      S_ISSUE: state_d = S_WAIT;
      S_WAIT: begin
        if (exec_done_i) state_d = seq_mode_q ? S_RPTCHK : S_IDLE;
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= S_IDLE;
      ptr_q      <= '0;
      cur_vec_q  <= '0;
      seq_mode_q <= 1'b0;
      seq_busy_q <= 1'b0;
      vec_busy_q <= '0;
      cmp_q      <= 1'b0;
    end else begin
      state_q <= state_d;
      if (ev_seq_go) begin
        seq_mode_q <= 1'b1;
        seq_busy_q <= 1'b1;
        cmp_q      <= 1'b0;
      end
      if (ev_vec_go) begin
        seq_mode_q <= 1'b0;
        cur_vec_q  <= vec_sel_i;
        vec_busy_q <= dec_oh[1];
      end
      if ((state_q == S_SEQCHK) && !seq_zero) ptr_q <= '0;
      if (state_q == S_ENTRY) cur_vec_q <= rd_vnum;
      if ((state_q == S_RPTCHK) && rpt_zero && (ptr_q != LAST)) ptr_q <= ptr_q + PTR_W'(1);
      if (ev_seq_finish || ev_abort) seq_busy_q <= 1'b0;
      if (ev_done) begin
        if (exec_mismatch_i) cmp_q <= 1'b1;
        if (!seq_mode_q)     vec_busy_q <= '0;
      end
    end
  end

  assign exec_req_o   = (state_q == S_ISSUE);
  assign exec_vec_o   = cur_vec_q;
  assign seq_busy_o   = seq_busy_q;
  assign vec_busy_o   = vec_busy_q;
  assign cmp_result_o = cmp_q;

endmodule

// File: rtl/vecseq_chk.sv
module vecseq_chk #(
  parameter int VNUM_W = 3,
  parameter int NVEC   = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic              seq_en_i,
  input logic [VNUM_W-1:0] vec_sel_i,
  input logic              in_idle,
  input logic              ev_abort,
  input logic              ev_seq_finish,
  input logic              exec_req_o,
  input logic [VNUM_W-1:0] exec_vec_o,
  input logic              seq_busy_o,
  input logic [NVEC-1:0]   vec_busy_o,
  input logic              cmp_result_o
);

  p_req_pulse_r13: assert property (@(posedge clk) disable iff (!rst_n)
    exec_req_o |=> !exec_req_o);

  p_req_legal_r4: assert property (@(posedge clk) disable iff (!rst_n)
    exec_req_o |-> (exec_vec_o != '0) && (exec_vec_o <= VNUM_W'(NVEC)));

  p_req_active_r4: assert property (@(posedge clk) disable iff (!rst_n)
    exec_req_o |-> (seq_busy_o || (|vec_busy_o)));

  p_busy_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(seq_busy_o && (|vec_busy_o)) && $onehot0(vec_busy_o));

  p_seq_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_idle && start_i && seq_en_i) |=> (seq_busy_o && !cmp_result_o));

  p_finish_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_seq_finish |=> (!seq_busy_o && in_idle));

  p_abort_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ev_abort |=> (!seq_busy_o && !exec_req_o && in_idle));

  p_ignored_start_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (in_idle && start_i && !seq_en_i &&
     ((vec_sel_i == '0) || (vec_sel_i > VNUM_W'(NVEC)))) |=> (in_idle && (vec_busy_o == '0)));

  p_cmp_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_result_o && !(in_idle && start_i && seq_en_i)) |=> cmp_result_o);

endmodule

bind vecseq_top vecseq_chk #(.VNUM_W(VNUM_W), .NVEC(NVEC)) u_vecseq_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .start_i      (start_i),
  .seq_en_i     (seq_en_i),
  .vec_sel_i    (vec_sel_i),
  .in_idle      (in_idle),
  .ev_abort     (ev_abort),
  .ev_seq_finish(ev_seq_finish),
  .exec_req_o   (exec_req_o),
  .exec_vec_o   (exec_vec_o),
  .seq_busy_o   (seq_busy_o),
  .vec_busy_o   (vec_busy_o),
  .cmp_result_o (cmp_result_o)
);

// File: tb/test_vecseq_top.sv
module test_vecseq_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_i = 1'b0;
  logic       seq_en_i = 1'b0;
  logic [2:0] vec_sel_i = '0;
  logic [7:0] seq_rpt_i = '0;
  logic [3:0] preload_i = 4'hF;
  logic       ent_we_i = 1'b0;
  logic [3:0] ent_addr_i = '0;
  logic [2:0] ent_vnum_i = '0;
  logic [7:0] ent_rpt_i = '0;
  logic       exec_req_o;
  logic [2:0] exec_vec_o;
  logic       exec_done_i = 1'b0;
  logic       exec_mismatch_i = 1'b0;
  logic       seq_busy_o;
  logic [3:0] vec_busy_o;
  logic       cmp_result_o;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  int log_v [0:1023];
  int n_log = 0;
  int exp_v [0:1023];
  bit mis_mode = 0;
  int ent_c [0:15];
  int ent_r [0:15];

  always #4 clk = ~clk;  // 125 MHz

  vecseq_top i_vecseq_top (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .seq_en_i(seq_en_i),
    .vec_sel_i(vec_sel_i), .seq_rpt_i(seq_rpt_i), .preload_i(preload_i),
    .ent_we_i(ent_we_i), .ent_addr_i(ent_addr_i), .ent_vnum_i(ent_vnum_i),
    .ent_rpt_i(ent_rpt_i), .exec_req_o(exec_req_o), .exec_vec_o(exec_vec_o),
    .exec_done_i(exec_done_i), .exec_mismatch_i(exec_mismatch_i),
    .seq_busy_o(seq_busy_o), .vec_busy_o(vec_busy_o), .cmp_result_o(cmp_result_o)
  );

  task automatic check(input string req, input int act, input int exp_val);
    n_chk++;
    if (act != exp_val) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp_val);
    end
  endtask

  task automatic report();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  // Watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
      report();
    end
  end

  // Downstream engine model: logs each request, answers after a short delay.
  initial begin
    forever begin
      @(negedge clk);
      if (exec_req_o) begin
        log_v[n_log] = int'(exec_vec_o);
        n_log++;
        repeat (2) @(negedge clk);
        exec_mismatch_i = mis_mode;
        exec_done_i = 1'b1;
        @(negedge clk);
        exec_done_i = 1'b0;
        exec_mismatch_i = 1'b0;
      end
    end
  end

  task automatic write_ent(input int a, input int code, input int rpt);
    @(negedge clk);
    ent_we_i = 1'b1; ent_addr_i = 4'(a); ent_vnum_i = 3'(code); ent_rpt_i = 8'(rpt);
    ent_c[a] = code; ent_r[a] = rpt;
    @(negedge clk);
    ent_we_i = 1'b0;
  endtask

  task automatic clear_list();
    for (int a = 0; a < 16; a++) write_ent(a, 0, 0);
  endtask

  // Independent walk of the list: returns expected request count.
  function automatic int model_run(input int passes, input logic [3:0] pre);
    int n = 0;
    for (int s = passes; s > 0; s--) begin
      for (int p = 0; p < 16; p++) begin
        if (ent_c[p] == 0 || ent_c[p] > 4) break;
        for (int r = 0; r < ent_r[p]; r++) begin
          if (!pre[ent_c[p]-1]) return n;
          exp_v[n] = ent_c[p];
          n++;
        end
      end
    end
    return n;
  endfunction

  task automatic wait_idle();
    int t = 0;
    @(negedge clk);
    while ((seq_busy_o || vec_busy_o != 0 || exec_done_i) && t < 20000) begin
      @(negedge clk);
      t++;
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic run_seq(input string req, input int passes);
    int base = n_log;
    int n_exp = model_run(passes, preload_i);
    @(negedge clk);
    seq_en_i = 1'b1; seq_rpt_i = 8'(passes); start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    check("R2 busy after start", int'(seq_busy_o), 1);
    check("R2 compare cleared", int'(cmp_result_o), 0);
    wait_idle();
    check({req, " request count"}, n_log - base, n_exp);
    for (int i = 0; i < n_exp && i < n_log - base; i++)
      check({req, " request code"}, log_v[base + i], exp_v[i]);
    check("R3 busy cleared at end", int'(seq_busy_o), 0);
  endtask

  task automatic t_reset();
    check("R1 req", int'(exec_req_o), 0);
    check("R1 seq busy", int'(seq_busy_o), 0);
    check("R1 vec busy", int'(vec_busy_o), 0);
    check("R1 compare", int'(cmp_result_o), 0);
  endtask

  task automatic t_basic();   // R4, R5
    clear_list();
    write_ent(0, 2, 3); write_ent(1, 4, 1);
    run_seq("R4 R5 nested counts", 2);
  endtask

  task automatic t_zero_pass();  // R3
    clear_list();
    write_ent(0, 1, 2);
    run_seq("R3 zero passes", 0);
  endtask

  task automatic t_illegal();  // R6
    clear_list();
    write_ent(0, 1, 1); write_ent(1, 6, 2); write_ent(2, 3, 1);
    run_seq("R6 unused code ends pass", 2);
    clear_list();
    write_ent(0, 4, 1); write_ent(1, 7, 1); write_ent(2, 2, 1);
    run_seq("R6 code seven", 3);
  endtask

  task automatic t_zero_rpt();  // R7
    clear_list();
    write_ent(0, 1, 0); write_ent(1, 3, 2); write_ent(2, 2, 0); write_ent(3, 4, 1);
    run_seq("R7 zero count skipped", 1);
  endtask

  task automatic t_full();  // R8
    for (int a = 0; a < 16; a++) write_ent(a, (a % 4) + 1, (a % 3 == 0) ? 1 : 0);
    run_seq("R8 full list wraps", 2);
  endtask

  task automatic t_abort();  // R9
    clear_list();
    write_ent(0, 1, 1); write_ent(1, 2, 2); write_ent(2, 3, 1);
    preload_i = 4'b1101;
    run_seq("R9 missing preload stops", 3);
    preload_i = 4'hF;
  endtask

  task automatic t_single();  // R10, R12
    int base = n_log;
    mis_mode = 1;
    @(negedge clk);
    seq_en_i = 1'b0; vec_sel_i = 3'd3; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    check("R10 vec busy one-hot", int'(vec_busy_o), 4);
    check("R10 request issued", int'(exec_req_o), 1);
    check("R10 request code", int'(exec_vec_o), 3);
    wait_idle();
    mis_mode = 0;
    check("R10 exactly one request", n_log - base, 1);
    check("R10 vec busy cleared", int'(vec_busy_o), 0);
    check("R12 compare set", int'(cmp_result_o), 1);
    repeat (3) @(negedge clk);
    check("R12 compare sticky", int'(cmp_result_o), 1);
    clear_list();
    write_ent(0, 1, 1);
    run_seq("R12 cleared by sequencer start", 1);
  endtask

  task automatic t_disabled();  // R11
    int base = n_log;
    for (int k = 0; k < 2; k++) begin
      @(negedge clk);
      seq_en_i = 1'b0; vec_sel_i = (k == 0) ? 3'd0 : 3'd6; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      check("R11 vec busy stays 0", int'(vec_busy_o), 0);
      check("R11 seq busy stays 0", int'(seq_busy_o), 0);
      repeat (4) @(negedge clk);
    end
    check("R11 no request", n_log - base, 0);
  endtask

  task automatic t_stray_done();  // R13
    @(negedge clk);
    exec_mismatch_i = 1'b1; exec_done_i = 1'b1;
    @(negedge clk);
    exec_done_i = 1'b0; exec_mismatch_i = 1'b0;
    @(negedge clk);
    check("R13 stray completion no compare", int'(cmp_result_o), 0);
    check("R13 stray completion no request", int'(exec_req_o), 0);
  endtask

  initial begin
    for (int a = 0; a < 16; a++) begin ent_c[a] = 0; ent_r[a] = 0; end
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_zero_pass();
    t_illegal();
    t_zero_rpt();
    t_full();
    t_abort();
    t_single();
    t_disabled();
    t_stray_done();
    report();
  end

endmodule